// File: doc/BRIEF.md
# Unpacked Decimal Adjust Unit

This block repairs a 16-bit accumulator after a byte addition or subtraction so that its low byte again holds one unpacked decimal digit. The low byte holds the digit. The high byte receives the decimal carry or borrow. The surrounding datapath presents the accumulator value, the incoming auxiliary (half) carry and an add/subtract select, and pulses `start`. One clock later the corrected accumulator and the six status flags are available on registered outputs, marked by a one-cycle `done` pulse.

The block does not split the repair into separate per-byte steps. It adds or subtracts a single constant, 0x106, across the whole 16-bit word. The +6/-6 repairs the low digit, and the ±0x100 moves the decimal carry or borrow into the high byte through the ordinary word carry chain. Arithmetic wraps modulo 2^16. After the adjustment, the upper nibble of the low byte is always cleared. All flags are defined explicitly, including overflow and sign, which are always zero.

Top module: `ascii_adj`

## Requirements
- R1: A correction is needed exactly when `acc_in[3:0]` is greater than 9 or `aux_in` is 1.
- R2: With a correction needed and `sub_mode`=0, `acc_out` equals (`acc_in` + 0x106) mod 2^16 with bits 7..4 then forced to 0.
- R3: With a correction needed and `sub_mode`=1, `acc_out` equals (`acc_in` - 0x106) mod 2^16 with bits 7..4 then forced to 0 (for example 0x0000 gives 0xFE0A).
- R4: With no correction needed, `acc_out` equals `acc_in` with bits 7..4 forced to 0, in either mode.
- R5: `carry_out` and `aux_out` are both 1 when a correction was applied and both 0 otherwise.
- R6: `ovf_out` and `sign_out` are always 0.
- R7: `zero_out` is 1 exactly when `acc_out[7:0]` is zero.
- R8: `parity_out` is 1 exactly when `acc_out[7:0]` holds an even number of one bits.
- R9: `done` is 1 in the cycle after `start` and 0 otherwise. Result and flags change only on a cycle where `start` was sampled high.
- R10: A synchronous active-high `rst` clears `acc_out`, all flags and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture and adjust the presented operands |
| sub_mode | input | 1 | 0 = after addition, 1 = after subtraction |
| acc_in | input | 16 | Accumulator value to adjust |
| aux_in | input | 1 | Incoming auxiliary (low-nibble) carry |
| acc_out | output | 16 | Corrected accumulator |
| carry_out | output | 1 | Carry flag |
| aux_out | output | 1 | Auxiliary carry flag |
| ovf_out | output | 1 | Overflow flag (always 0) |
| sign_out | output | 1 | Sign flag (always 0) |
| zero_out | output | 1 | Zero flag of the low byte |
| parity_out | output | 1 | Even parity of the low byte |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the unit with its default parameters: a 16-bit accumulator, an 8-bit digit lane, a digit limit of 9 and a repair step of 6. These values let the bench reach the word-wide wrap cases: 0xFFFF plus the constant rolls over to 0x0105, and 0x0000 minus it rolls over to 0xFEFA. They also let it reach the nibble boundary between 9 and 10. Random words in both modes, with the auxiliary carry set and cleared, are mixed with directed cases that make the low byte zero so that the zero and parity flags take both values.

// File: rtl/ascii_adj_pkg.sv
package ascii_adj_pkg;
  typedef struct packed {
    logic carry;
    logic aux;
    logic ovf;
    logic sign;
    logic zero;
    logic parity;
  } adj_flags_t;
endpackage

// File: rtl/ascii_adj_detect.sv
module ascii_adj_detect #(
  parameter int NIB_W   = 4,
  parameter int NIB_MAX = 9
) (
  input  logic [NIB_W-1:0] low_nib,
  input  logic             aux_in,
  output logic             need_fix
);
  always_comb begin
    need_fix = aux_in || (int'(low_nib) > NIB_MAX);
  end
endmodule

// File: rtl/ascii_adj_arith.sv
module ascii_adj_arith #(
  parameter int ACC_W  = 16,
  parameter int LANE_W = 8,
  parameter int NIB_W  = 4,
  parameter int STEP   = 6
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic             need_fix,
  input  logic             sub_mode,
  output logic [ACC_W-1:0] acc_fixed
);
  localparam logic [ACC_W-1:0] ADJ = ACC_W'((1 << LANE_W) + STEP);

  logic [ACC_W-1:0] raw;

  always_comb begin
    if (!need_fix)     raw = acc_in;
    else if (sub_mode) raw = acc_in - ADJ;
    else               raw = acc_in + ADJ;
    acc_fixed = raw;
    acc_fixed[LANE_W-1:NIB_W] = '0;
  end
endmodule

// File: rtl/ascii_adj_flags.sv
module ascii_adj_flags
  import ascii_adj_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane,
  input  logic              need_fix,
  output adj_flags_t        flags
);
  always_comb begin
    flags.carry  = need_fix;
    flags.aux    = need_fix;
    flags.ovf    = 1'b0;
    flags.sign   = 1'b0;
    flags.zero   = (lane == '0);
    flags.parity = ~(^lane);
  end
endmodule

// File: rtl/ascii_adj.sv
module ascii_adj
  import ascii_adj_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int LANE_W  = 8,
  parameter int NIB_W   = 4,
  parameter int NIB_MAX = 9,
  parameter int STEP    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sub_mode,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             aux_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             carry_out,
  output logic             aux_out,
  output logic             ovf_out,
  output logic             sign_out,
  output logic             zero_out,
  output logic             parity_out,
  output logic             done
);
  logic             need_fix;
  logic [ACC_W-1:0] acc_fixed;
  adj_flags_t       flags_c;
  adj_flags_t       flags_q;

  ascii_adj_detect #(.NIB_W(NIB_W), .NIB_MAX(NIB_MAX)) u_detect (
    .low_nib (acc_in[NIB_W-1:0]),
    .aux_in  (aux_in),
    .need_fix(need_fix)
  );

  ascii_adj_arith #(.ACC_W(ACC_W), .LANE_W(LANE_W), .NIB_W(NIB_W), .STEP(STEP)) u_arith (
    .acc_in   (acc_in),
    .need_fix (need_fix),
    .sub_mode (sub_mode),
    .acc_fixed(acc_fixed)
  );

  ascii_adj_flags #(.LANE_W(LANE_W)) u_flags (
    .lane    (acc_fixed[LANE_W-1:0]),
    .need_fix(need_fix),
    .flags   (flags_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      flags_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        acc_out <= acc_fixed;
        flags_q <= flags_c;
      end
    end
  end

  assign carry_out  = flags_q.carry;
  assign aux_out    = flags_q.aux;
  assign ovf_out    = flags_q.ovf;
  assign sign_out   = flags_q.sign;
  assign zero_out   = flags_q.zero;
  assign parity_out = flags_q.parity;
endmodule

// File: rtl/ascii_adj_checker.sv
module ascii_adj_checker #(
  parameter int ACC_W  = 16,
  parameter int LANE_W = 8,
  parameter int NIB_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             aux_in,
  input logic [ACC_W-1:0] acc_in,
  input logic [ACC_W-1:0] acc_out,
  input logic             carry_out,
  input logic             aux_out,
  input logic             ovf_out,
  input logic             sign_out,
  input logic             zero_out,
  input logic             parity_out,
  input logic             done
);
  p_need_fix_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> carry_out == ($past(aux_in) || ($past(acc_in[3:0]) > 4'd9)));

  p_nibble_clear_r2: assert property (@(posedge clk) disable iff (rst)
    acc_out[LANE_W-1:NIB_W] == '0);

  p_flag_pair_r5: assert property (@(posedge clk) disable iff (rst)
    carry_out == aux_out);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    !ovf_out && !sign_out);

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> zero_out == (acc_out[LANE_W-1:0] == '0));

  p_parity_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> parity_out == ($countones(acc_out[LANE_W-1:0]) % 2 == 0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done && $stable(acc_out) && $stable(carry_out));
endmodule

bind ascii_adj ascii_adj_checker #(.ACC_W(ACC_W), .LANE_W(LANE_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .aux_in(aux_in), .acc_in(acc_in),
  .acc_out(acc_out), .carry_out(carry_out), .aux_out(aux_out), .ovf_out(ovf_out),
  .sign_out(sign_out), .zero_out(zero_out), .parity_out(parity_out), .done(done)
);

// File: tb/ascii_adj_bench.sv
module ascii_adj_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        sub_mode = 1'b0;
  logic [15:0] acc_in = '0;
  logic        aux_in = 1'b0;
  logic [15:0] acc_out;
  logic        carry_out, aux_out, ovf_out, sign_out, zero_out, parity_out, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ascii_adj u_ascii_adj (
    .clk(clk), .rst(rst), .start(start), .sub_mode(sub_mode), .acc_in(acc_in),
    .aux_in(aux_in), .acc_out(acc_out), .carry_out(carry_out), .aux_out(aux_out),
    .ovf_out(ovf_out), .sign_out(sign_out), .zero_out(zero_out),
    .parity_out(parity_out), .done(done)
  );

  function automatic bit exp_need(input logic [15:0] a, input logic ax);
    return ax || (a[3:0] > 4'd9);
  endfunction

  function automatic logic [15:0] exp_acc(input logic [15:0] a, input logic ax, input logic sb);
    logic [15:0] r;
    r = a;
    if (exp_need(a, ax)) r = sb ? a - 16'h0106 : a + 16'h0106;
    r[7:4] = 4'h0;
    return r;
  endfunction

  function automatic logic exp_parity(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return (n % 2) == 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input logic ax, input logic sb);
    logic [15:0] e;
    logic        n;
    e = exp_acc(a, ax, sb);
    n = exp_need(a, ax);
    @(negedge clk);
    acc_in = a; aux_in = ax; sub_mode = sb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sb ? "R3 acc" : (n ? "R2 acc" : "R4 acc"), 32'(acc_out), 32'(e));
    check("R1/R5 carry", 32'(carry_out), 32'(n));
    check("R5 aux", 32'(aux_out), 32'(n));
    check("R6 ovf/sign", {30'd0, ovf_out, sign_out}, 32'd0);
    check("R7 zero", 32'(zero_out), 32'(e[7:0] == 8'h00));
    check("R8 parity", 32'(parity_out), 32'(exp_parity(e[7:0])));
    check("R9 done", 32'(done), 32'd1);
    // R9: with start low, inputs change but outputs hold
    acc_in = ~a; aux_in = ~ax;
    @(negedge clk);
    check("R9 no done", 32'(done), 32'd0);
    check("R9 hold", 32'(acc_out), 32'(e));
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R10 acc", 32'(acc_out), 32'd0);
    check("R10 flags", {26'd0, carry_out, aux_out, ovf_out, sign_out, zero_out, parity_out}, 32'd0);
    check("R10 done", 32'(done), 32'd0);
    rst = 1'b0;
    // directed corners
    run(16'h0009, 1'b0, 1'b0);  // R4 boundary at 9
    run(16'h000A, 1'b0, 1'b0);  // R2 boundary at 10 -> 0x0100, zero set
    run(16'hFFFF, 1'b0, 1'b0);  // R2 wrap -> 0x0105
    run(16'h0000, 1'b1, 1'b1);  // R3 wrap -> 0xFE0A
    run(16'h0000, 1'b0, 1'b1);  // R4 no fix, zero
    run(16'h12F3, 1'b1, 1'b0);  // R1 aux-driven fix
    run(16'h3406, 1'b0, 1'b1);  // R4 subtract no fix
    run(16'h00FA, 1'b0, 1'b1);  // R3 fix with nibble > 9
    for (int k = 0; k < 300; k++) begin
      run(16'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule